// File: doc/BRIEF.md
# Sector page-load write controller

This block sequences page writes inside one flash segment. A host issues a burst of byte writes with active-low chip-enable and write-enable strobes. Every byte in the burst names the same sector. The block keeps each byte in a sector-sized page buffer and watches the gap after each strobe ends. When no new strobe starts within the load window, loading is over. The block then enters a self-timed programming period and writes every byte of the sector to the array through a plain write port. Bytes the host never loaded go out as all-ones.

A write is seen only while both strobes are low. The address comes from the moment the later of the two strobes falls. The data comes from the moment the first of them rises. Both strobes are synchronised to the clock, and a filter drops pulses shorter than a set number of clock cycles. The load window and the programming period count cycles of an external timebase enable, so the same block works across clock rates. While programming, the busy output is high and all new strobes are ignored. The non-volatile array is modelled as an ordinary RAM write port.

Top module: `sector_load_ctrl`

## Requirements
- R1: After reset, busy and arr_we are low. No programming starts without a write.
- R2: The sector and byte address are sampled when the combined strobe becomes active, meaning both ce_n and we_n are low. The data byte is sampled when the combined strobe ends. An address shown while only one strobe is low, or data replaced before the end of the strobe, is not used.
- R3: A combined strobe that lasts fewer than FILT_CYC clock cycles has no effect. It loads nothing and never starts programming.
- R4: Loading ends, and busy rises, once LOAD_GAP timebase cycles pass after an accepted strobe ends with no new accepted strobe starting. A strobe that starts within the window keeps loading open.
- R5: busy stays high for exactly PROG_CYC timebase cycles.
- R6: During programming, arr_we writes every byte address of the sector exactly once. The writes run in ascending order, starting at byte 0. arr_addr is {sector, byte}, with the sector held constant across the pass.
- R7: Each loaded byte is programmed with its loaded value. Each byte not loaded is programmed as 8'hFF.
- R8: A strobe that arrives while busy is high loads nothing and does not start a later programming period.
- R9: During loading, a strobe that names a sector other than the first loaded byte's sector is ignored.
- R10: After programming, the page buffer is empty. Bytes loaded for the previous sector are programmed as 8'hFF in the next sector.
- R11: Loading the same byte twice keeps the later value.
- R12: The load window and the programming period advance only on cycles where tick is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timebase enable for the load window and programming timers |
| ce_n | input | 1 | Active-low chip enable strobe |
| we_n | input | 1 | Active-low write enable strobe |
| wr_sec_addr | input | SEC_W | Sector address of the write |
| wr_byte_addr | input | BYTE_W | Byte address within the sector |
| wr_data | input | DATA_W | Write data byte |
| busy | output | 1 | High during the self-timed programming period |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | SEC_W+BYTE_W | Array address {sector, byte} |
| arr_data | output | DATA_W | Array write data |

## Verification
The hardest case to reach is a load that almost times out. A new strobe has to fall just inside the window, after a long idle stretch between two accepted bytes. The stimulus puts an idle gap of LOAD_GAP minus a margin between two bytes of the vector table. The bench then checks that the sector is programmed once and holds the bytes from both sides of the gap. A second hard case is a strobe during programming, which must leave no trace. The bench drives a full write right after busy rises. It then watches for a second programming pass that must never come.

// File: rtl/slc_pkg.sv
package slc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOAD = 2'd1,
      ST_PROG = 2'd2
   } slc_state_e;
endpackage

// File: rtl/slc_strobe_filter.sv
module slc_strobe_filter #(
   parameter int SYNC = 2,
   parameter int FILT = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic rise,
   output logic fall
);
   logic [SYNC-1:0] sh;
   logic            s;
   logic            level;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[SYNC-2:0], raw};
   end
   assign s = sh[SYNC-1];

   generate
      if (FILT <= 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               level <= 1'b0;
               rise  <= 1'b0;
               fall  <= 1'b0;
            end else begin
               level <= s;
               rise  <= s & ~level;
               fall  <= ~s & level;
            end
         end
      end else begin : g_count
         localparam int CW = $clog2(FILT);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               level <= 1'b0;
               rise  <= 1'b0;
               fall  <= 1'b0;
               cnt   <= '0;
            end else begin
               rise <= 1'b0;
               fall <= 1'b0;
               if (s == level) begin
                  cnt <= '0;
               end else if (cnt == CW'(FILT-1)) begin
                  level <= s;
                  rise  <= s;
                  fall  <= ~s;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/slc_tick_counter.sv
module slc_tick_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   output logic [W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (en)  cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/slc_page_buf.sv
module slc_page_buf #(
   parameter int AW = 8,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int N = 1 << AW;

   logic [DW-1:0] mem [N];
   logic [N-1:0]  valid;

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   valid <= '0;
      else if (clr) valid <= '0;
      else if (we)  valid[waddr] <= 1'b1;
   end

   assign rdata = valid[raddr] ? mem[raddr] : {DW{1'b1}};
endmodule

// File: rtl/sector_load_ctrl.sv
module sector_load_ctrl
   import slc_pkg::*;
#(
   parameter int SEC_W       = 11,
   parameter int BYTE_W      = 8,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int FILT_CYC    = 3,
   parameter int LOAD_GAP    = 40,
   parameter int PROG_CYC    = 300
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tick,
   input  logic                    ce_n,
   input  logic                    we_n,
   input  logic [SEC_W-1:0]        wr_sec_addr,
   input  logic [BYTE_W-1:0]       wr_byte_addr,
   input  logic [DATA_W-1:0]       wr_data,
   output logic                    busy,
   output logic                    arr_we,
   output logic [SEC_W+BYTE_W-1:0] arr_addr,
   output logic [DATA_W-1:0]       arr_data
);
   localparam int NB     = 1 << BYTE_W;
   localparam int GAP_W  = $clog2(LOAD_GAP + 1);
   localparam int PRG_W  = $clog2(PROG_CYC + 1);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (PROG_CYC <= NB) begin : g_bad_prog
         $error("PROG_CYC must exceed the number of bytes in a sector");
      end
      if (LOAD_GAP < 2) begin : g_bad_gap
         $error("LOAD_GAP must be at least 2");
      end
   endgenerate

   slc_state_e          st;
   logic [SEC_W-1:0]    sec_q;
   logic [BYTE_W-1:0]   byte_q;
   logic                acc;
   logic [BYTE_W-1:0]   wr_idx;
   logic                wr_act;
   logic                s_rise, s_fall;
   logic [GAP_W-1:0]    gap_cnt;
   logic [PRG_W-1:0]    prog_cnt;
   logic [DATA_W-1:0]   rd_byte;
   logic                sec_hit, take_rise, buf_we, gap_done, prog_done;

   slc_strobe_filter #(.SYNC(SYNC_STAGES), .FILT(FILT_CYC)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (~ce_n & ~we_n),
      .rise (s_rise),
      .fall (s_fall)
   );

   slc_tick_counter #(.W(GAP_W)) u_gap (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  ((st != ST_LOAD) | acc),
      .en   (tick),
      .cnt  (gap_cnt)
   );

   slc_tick_counter #(.W(PRG_W)) u_prog (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (st != ST_PROG),
      .en   (tick),
      .cnt  (prog_cnt)
   );

   assign sec_hit   = (wr_sec_addr == sec_q);
   assign take_rise = s_rise & ~acc & sec_hit;
   assign buf_we    = (st == ST_LOAD) & s_fall & acc;
   assign gap_done  = (st == ST_LOAD) & ~acc & tick & ~take_rise &
                      (gap_cnt == GAP_W'(LOAD_GAP - 1));
   assign prog_done = (st == ST_PROG) & tick & (prog_cnt == PRG_W'(PROG_CYC - 1));

   slc_page_buf #(.AW(BYTE_W), .DW(DATA_W)) u_buf (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (prog_done),
      .we   (buf_we),
      .waddr(byte_q),
      .wdata(wr_data),
      .raddr(wr_idx),
      .rdata(rd_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         sec_q  <= '0;
         byte_q <= '0;
         acc    <= 1'b0;
         wr_idx <= '0;
         wr_act <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (s_rise) begin
                  sec_q  <= wr_sec_addr;
                  byte_q <= wr_byte_addr;
                  acc    <= 1'b1;
                  st     <= ST_LOAD;
               end
            end
            ST_LOAD: begin
               if (take_rise) begin
                  byte_q <= wr_byte_addr;
                  acc    <= 1'b1;
               end else if (s_fall && acc) begin
                  acc <= 1'b0;
               end else if (gap_done) begin
                  st     <= ST_PROG;
                  wr_idx <= '0;
                  wr_act <= 1'b1;
               end
            end
            ST_PROG: begin
               if (wr_act) begin
                  wr_idx <= wr_idx + 1'b1;
                  if (wr_idx == BYTE_W'(NB - 1)) wr_act <= 1'b0;
               end
               if (prog_done) st <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arr_we   <= 1'b0;
         arr_addr <= '0;
         arr_data <= '0;
      end else begin
         arr_we   <= wr_act;
         arr_addr <= {sec_q, wr_idx};
         arr_data <= rd_byte;
      end
   end

   assign busy = (st == ST_PROG);
endmodule

// File: rtl/slc_checker.sv
module slc_checker #(
   parameter int SEC_W    = 11,
   parameter int BYTE_W   = 8,
   parameter int PROG_CYC = 300
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    tick,
   input logic                    busy,
   input logic                    arr_we,
   input logic [SEC_W+BYTE_W-1:0] arr_addr
);
   logic [31:0] busy_ticks;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            busy_ticks <= '0;
      else if (busy && tick) busy_ticks <= busy_ticks + 1;
      else if (!busy)        busy_ticks <= '0;
   end

   // R6
   we_in_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> busy);

   // R6
   first_byte_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(arr_we) |-> (arr_addr[BYTE_W-1:0] == '0));

   // R6
   ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_we && $past(arr_we)) |->
      ((arr_addr[BYTE_W-1:0] - $past(arr_addr[BYTE_W-1:0])) == BYTE_W'(1)));

   // R6
   sector_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_we && $past(arr_we)) |->
      $stable(arr_addr[SEC_W+BYTE_W-1:BYTE_W]));

   // R5
   prog_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (busy_ticks == PROG_CYC));
endmodule

bind sector_load_ctrl slc_checker #(
   .SEC_W   (SEC_W),
   .BYTE_W  (BYTE_W),
   .PROG_CYC(PROG_CYC)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick    (tick),
   .busy    (busy),
   .arr_we  (arr_we),
   .arr_addr(arr_addr)
);

// File: tb/tb_sector_load_ctrl.sv
module tb_sector_load_ctrl;
   localparam int SEC_W    = 11;
   localparam int BYTE_W   = 8;
   localparam int DATA_W   = 8;
   localparam int FILT_CYC = 3;
   localparam int LOAD_GAP = 40;
   localparam int PROG_CYC = 300;
   localparam int NB       = 1 << BYTE_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b1;
   logic half = 1'b0;
   logic ce_n = 1'b1;
   logic we_n = 1'b1;
   logic [SEC_W-1:0]        wr_sec_addr = '0;
   logic [BYTE_W-1:0]       wr_byte_addr = '0;
   logic [DATA_W-1:0]       wr_data = '0;
   logic                    busy, arr_we;
   logic [SEC_W+BYTE_W-1:0] arr_addr;
   logic [DATA_W-1:0]       arr_data;

   int total = 0;
   int bad = 0;

   // mirror of the array write port for the latest programming pass
   logic [DATA_W-1:0] mirror [NB];
   logic [DATA_W-1:0] expv [NB];
   int                nwr = 0;
   logic              order_bad = 1'b0;
   logic [SEC_W-1:0]  seen_sec = '0;
   logic [BYTE_W-1:0] last_b = '0;

   always #5 clk = ~clk;

   always @(negedge clk) tick <= half ? ~tick : 1'b1;

   sector_load_ctrl #(
      .SEC_W(SEC_W), .BYTE_W(BYTE_W), .DATA_W(DATA_W), .SYNC_STAGES(2),
      .FILT_CYC(FILT_CYC), .LOAD_GAP(LOAD_GAP), .PROG_CYC(PROG_CYC)
   ) dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .ce_n(ce_n), .we_n(we_n),
      .wr_sec_addr(wr_sec_addr), .wr_byte_addr(wr_byte_addr), .wr_data(wr_data),
      .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr), .arr_data(arr_data)
   );

   always @(negedge clk) begin
      if (rst_n && arr_we) begin
         if (nwr == 0 && arr_addr[BYTE_W-1:0] != '0) order_bad = 1'b1;
         if (nwr > 0 && arr_addr[BYTE_W-1:0] != BYTE_W'(last_b + 1'b1)) order_bad = 1'b1;
         if (nwr > 0 && arr_addr[SEC_W+BYTE_W-1:BYTE_W] != seen_sec) order_bad = 1'b1;
         seen_sec = arr_addr[SEC_W+BYTE_W-1:BYTE_W];
         last_b   = arr_addr[BYTE_W-1:0];
         mirror[arr_addr[BYTE_W-1:0]] = arr_data;
         nwr++;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clear_model();
      for (int i = 0; i < NB; i++) begin
         expv[i]   = 8'hFF;
         mirror[i] = 8'h00;
      end
      nwr = 0;
      order_bad = 1'b0;
   endtask

   task automatic put(input logic [SEC_W-1:0] s, input logic [BYTE_W-1:0] b,
                      input logic [DATA_W-1:0] d);
      @(negedge clk);
      wr_sec_addr = s; wr_byte_addr = b; wr_data = d; ce_n = 1'b0;
      @(negedge clk);
      we_n = 1'b0;
      repeat (8) @(negedge clk);
      we_n = 1'b1;
      repeat (2) @(negedge clk);
      ce_n = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic wait_busy(input int lim, output logic ok);
      ok = 1'b0;
      for (int i = 0; i < lim; i++) begin
         @(negedge clk);
         if (busy) begin ok = 1'b1; break; end
      end
   endtask

   task automatic busy_len(output int n);
      n = 0;
      while (busy) begin n++; @(negedge clk); end
   endtask

   task automatic cmp_all(input string req);
      int mism = 0;
      for (int i = 0; i < NB; i++) if (mirror[i] !== expv[i]) mism++;
      chk(req, mism, 0);
   endtask

   // {byte address, data}
   localparam logic [15:0] LOADS [8] = '{
      16'h00_A1, 16'h01_B2, 16'h10_C3, 16'hFF_D4,
      16'h80_E5, 16'h10_5A, 16'h7F_00, 16'h20_FF
   };

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired, run hung");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic ok;
      int   n;
      int   hits;
      clear_model();
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 busy in reset", busy, 0);
      chk("R1 arr_we in reset", arr_we, 0);
      rst_n = 1'b1;
      repeat (LOAD_GAP + 20) @(negedge clk);
      chk("R1 idle without writes", busy, 0);

      // main load from vector table, sector 0x123
      clear_model();
      for (int k = 0; k < 8; k++) begin
         put(11'h123, LOADS[k][15:8], LOADS[k][7:0]);
         expv[LOADS[k][15:8]] = LOADS[k][7:0];
         if (k == 3) put(11'h124, 8'h05, 8'h99);      // R9 foreign sector
         if (k == 5) repeat (LOAD_GAP - 20) @(negedge clk); // R4 long gap
         chk("R4 loading still open", busy, 0);
      end
      repeat (LOAD_GAP - 8) @(negedge clk);
      chk("R4 no early end", busy, 0);
      wait_busy(40, ok);
      chk("R4 busy after gap", ok, 1);
      busy_len(n);
      chk("R5 busy length", n, PROG_CYC);
      chk("R6 write count", nwr, NB);
      chk("R6 order and sector", order_bad, 0);
      chk("R6 sector", seen_sec, 11'h123);
      cmp_all("R7 array contents");
      chk("R7 unloaded byte FF", mirror[8'h42], 8'hFF);
      chk("R9 foreign byte untouched", mirror[8'h05], 8'hFF);
      chk("R11 overwrite keeps later", mirror[8'h10], 8'h5A);

      // R3 short strobes
      clear_model();
      @(negedge clk); ce_n = 1'b0; we_n = 1'b0;
      @(negedge clk); we_n = 1'b1;
      repeat (4) @(negedge clk); we_n = 1'b0;
      repeat (FILT_CYC - 1) @(negedge clk); we_n = 1'b1; ce_n = 1'b1;
      hits = 0;
      for (int i = 0; i < LOAD_GAP + 40; i++) begin
         @(negedge clk);
         if (busy) hits++;
      end
      chk("R3 glitch never programs", hits, 0);
      chk("R3 glitch no array writes", nwr, 0);

      // R8 strobe during programming
      clear_model();
      put(11'h055, 8'h01, 8'hA5);
      expv[8'h01] = 8'hA5;
      wait_busy(LOAD_GAP + 20, ok);
      chk("R8 program started", ok, 1);
      put(11'h055, 8'h02, 8'h77);
      while (busy) @(negedge clk);
      hits = 0;
      for (int i = 0; i < LOAD_GAP + 60; i++) begin
         @(negedge clk);
         if (busy) hits++;
      end
      chk("R8 no second program", hits, 0);
      chk("R8 busy-time byte not loaded", mirror[8'h02], 8'hFF);
      cmp_all("R8 contents");

      // R2 capture points and R10 buffer cleared
      clear_model();
      @(negedge clk);
      wr_sec_addr = 11'h7FF; wr_byte_addr = 8'h50; wr_data = 8'h11; ce_n = 1'b0;
      repeat (10) @(negedge clk);
      wr_byte_addr = 8'h03; we_n = 1'b0;
      repeat (8) @(negedge clk);
      wr_data = 8'h22;
      repeat (3) @(negedge clk);
      we_n = 1'b1;
      repeat (8) @(negedge clk);
      ce_n = 1'b1;
      wait_busy(LOAD_GAP + 20, ok);
      chk("R2 program started", ok, 1);
      while (busy) @(negedge clk);
      chk("R2 address at later falling strobe", mirror[8'h03], 8'h22);
      chk("R2 early address unused", mirror[8'h50], 8'hFF);
      chk("R10 old sector byte cleared", mirror[8'h10], 8'hFF);
      chk("R10 old byte 00 cleared", mirror[8'h00], 8'hFF);
      chk("R6 sector 7FF", seen_sec, 11'h7FF);

      // R12 half-rate timebase
      clear_model();
      half = 1'b1;
      put(11'h200, 8'h00, 8'h3C);
      repeat (LOAD_GAP) @(negedge clk);
      chk("R12 window stretched", busy, 0);
      wait_busy(2 * LOAD_GAP + 20, ok);
      chk("R12 program started", ok, 1);
      busy_len(n);
      chk("R12 busy stretched", (n >= 2 * PROG_CYC - 2) && (n <= 2 * PROG_CYC + 2), 1);
      chk("R12 contents", mirror[8'h00], 8'h3C);
      half = 1'b0;

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule